// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Unit

This block decides, for a five-stage in-order integer pipeline (fetch, decode, operand read, execute, result write, one cycle each), when a younger instruction must wait for an older one and where each of its source operands comes from. It takes the source and destination register fields of the instruction in decode. It carries the destination tags of the instructions in operand read, execute and write through its own tag registers, which follow the same stall and bubble rules as the datapath.

When a source of the decode instruction matches a pending destination that cannot yet be delivered, the block raises a stall. Fetch and decode hold and an empty slot with no destination moves into operand read. For the instruction in operand read it drives one select per source operand. The select picks the register file, the result latch of the write stage, or the live output of the execute stage. A static mode input sets how far results are bypassed. The register file does not pass a write through to a read in the same cycle. The decoder, ALU and register file are outside the block.

Top module: `hzd_bypass_unit`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises with an empty pipeline, stall_o is low and every opsel_o field is 0 (register file).
- R2: In mode 0 (no bypass), a consumer directly behind its producer stalls 2 cycles, one instruction between them gives 1 stall cycle, two or more give none, and every opsel_o field stays 0.
- R3: In mode 1 (basic bypass), a consumer directly behind its producer stalls 1 cycle and then reads that operand with opsel 1 (write-stage latch). With one instruction between them there is no stall and opsel is 1.
- R4: In mode 2 (full bypass), nothing stalls. A consumer directly behind its producer gets opsel 2 (execute result), at distance two it gets opsel 1, and at distance three it gets 0.
- R5: A source or destination of register 0 never forms a dependency: no stall and opsel 0.
- R6: An older instruction whose write-enable is low never forms a dependency, even if its register field matches.
- R7: When the execute and write stages both hold the matching register, the execute stage (younger producer) is selected (opsel 2).
- R8: The two source operands are checked independently. opsel_o[1:0] serves the first source and opsel_o[3:2] the second. Stall is raised if either source needs it.
- R9: During a stall the decode instruction is held and re-checked each cycle. The slot inserted behind it carries no destination. A stall lasts at most one cycle in mode 1 and at most two in mode 0, and every program leaves the same register values as sequential execution.
- R10: Mode 3 behaves exactly as mode 0.
- R11: An instruction whose sources match no pending destination never stalls and reads with opsel 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bypass mode: 0 none, 1 basic, 2 full, 3 as none |
| dec_rs_i | input | NUM_SRC*REG_W | Source register numbers of the decode instruction, source 0 in the low field |
| dec_rs_use_i | input | NUM_SRC | Source valid flags of the decode instruction |
| dec_rd_i | input | REG_W | Destination register of the decode instruction |
| dec_rd_we_i | input | 1 | Destination write-enable of the decode instruction |
| stall_o | output | 1 | Hold fetch and decode and insert an empty slot |
| opsel_o | output | NUM_SRC*2 | Per-source operand select for the operand-read instruction |

## Verification
On every cycle the assertions check that mode 0 never selects a bypass path and that mode 1 never selects the execute result. They also check that stall runs stay within one cycle in mode 1 and two in mode 0, that the slot behind a stall carries no destination, and that a register-0 source reads the register file. The stall counts per dependency distance, the priority of execute over write, and the independent per-operand choice are shown only by the bench's scenarios. So is the fact that the chosen sources yield correct register contents. The bench runs short programs through a model of the datapath and compares the result with sequential execution.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int unsigned OPSEL_W = 2;

  typedef enum logic [1:0] {
    BYP_NONE  = 2'd0,
    BYP_BASIC = 2'd1,
    BYP_FULL  = 2'd2,
    BYP_RSVD  = 2'd3
  } byp_mode_e;

  typedef enum logic [OPSEL_W-1:0] {
    OPSEL_RF = 2'd0,
    OPSEL_WB = 2'd1,
    OPSEL_EX = 2'd2
  } opsel_e;

endpackage

// File: rtl/hzd_tag_cmp.sv
module hzd_tag_cmp #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] src_i,
  input  logic             src_use_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             dst_we_i,
  output logic             hit_o
);

  logic dst_live;

  // register 0 is constant zero, never a producer
  assign dst_live = dst_we_i && (dst_i != '0);
  assign hit_o    = src_use_i && dst_live && (dst_i == src_i);

endmodule

// File: rtl/hzd_tag_pipe.sv
module hzd_tag_pipe #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned REG_W   = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          stall_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_rs_i,
  input  logic [NUM_SRC-1:0]            dec_use_i,
  input  logic [REG_W-1:0]              dec_rd_i,
  input  logic                          dec_we_i,
  output logic [NUM_SRC-1:0][REG_W-1:0] rd_rs_o,
  output logic [NUM_SRC-1:0]            rd_use_o,
  output logic [REG_W-1:0]              rd_rd_o,
  output logic                          rd_we_o,
  output logic [REG_W-1:0]              ex_rd_o,
  output logic                          ex_we_o,
  output logic [REG_W-1:0]              wb_rd_o,
  output logic                          wb_we_o
);

  logic [NUM_SRC-1:0][REG_W-1:0] rd_rs_q;
  logic [NUM_SRC-1:0]            rd_use_q;
  logic [REG_W-1:0]              rd_rd_q, ex_rd_q, wb_rd_q;
  logic                          rd_we_q, ex_we_q, wb_we_q;

  // operand-read slot: takes decode, or an empty slot while decode is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_rs_q  <= '0;
      rd_use_q <= '0;
      rd_rd_q  <= '0;
      rd_we_q  <= 1'b0;
    end else if (stall_i) begin
      rd_rs_q  <= '0;
      rd_use_q <= '0;
      rd_rd_q  <= '0;
      rd_we_q  <= 1'b0;
    end else begin
      rd_rs_q  <= dec_rs_i;
      rd_use_q <= dec_use_i;
      rd_rd_q  <= dec_rd_i;
      rd_we_q  <= dec_we_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ex_rd_q <= '0;
      ex_we_q <= 1'b0;
      wb_rd_q <= '0;
      wb_we_q <= 1'b0;
    end else begin
      ex_rd_q <= rd_rd_q;
      ex_we_q <= rd_we_q;
      wb_rd_q <= ex_rd_q;
      wb_we_q <= ex_we_q;
    end
  end

  assign rd_rs_o  = rd_rs_q;
  assign rd_use_o = rd_use_q;
  assign rd_rd_o  = rd_rd_q;
  assign rd_we_o  = rd_we_q;
  assign ex_rd_o  = ex_rd_q;
  assign ex_we_o  = ex_we_q;
  assign wb_rd_o  = wb_rd_q;
  assign wb_we_o  = wb_we_q;

  AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (!rd_we_q && (rd_use_q == '0))); // R9

endmodule

// File: rtl/hzd_stall_detect.sv
module hzd_stall_detect
  import hzd_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned REG_W   = 5
) (
  input  logic [1:0]                    mode_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_rs_i,
  input  logic [NUM_SRC-1:0]            dec_use_i,
  input  logic [REG_W-1:0]              rd_rd_i,
  input  logic                          rd_we_i,
  input  logic [REG_W-1:0]              ex_rd_i,
  input  logic                          ex_we_i,
  output logic                          stall_o
);

  logic [NUM_SRC-1:0] hit_rd, hit_ex, need;
  byp_mode_e          mode;

  assign mode = byp_mode_e'(mode_i);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_tag_cmp #(.REG_W(REG_W)) u_cmp_rd (
      .src_i     (dec_rs_i[g]),
      .src_use_i (dec_use_i[g]),
      .dst_i     (rd_rd_i),
      .dst_we_i  (rd_we_i),
      .hit_o     (hit_rd[g])
    );
    hzd_tag_cmp #(.REG_W(REG_W)) u_cmp_ex (
      .src_i     (dec_rs_i[g]),
      .src_use_i (dec_use_i[g]),
      .dst_i     (ex_rd_i),
      .dst_we_i  (ex_we_i),
      .hit_o     (hit_ex[g])
    );
  end

  // producer one ahead sits in operand read, two ahead in execute
  always_comb begin
    for (int i = 0; i < int'(NUM_SRC); i++) begin
      case (mode)
        BYP_FULL:  need[i] = 1'b0;
        BYP_BASIC: need[i] = hit_rd[i];
        default:   need[i] = hit_rd[i] | hit_ex[i];
      endcase
    end
  end

  assign stall_o = |need;

endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned REG_W   = 5
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0]   rd_rs_i,
  input  logic [NUM_SRC-1:0]              rd_use_i,
  input  logic [REG_W-1:0]                ex_rd_i,
  input  logic                            ex_we_i,
  input  logic [REG_W-1:0]                wb_rd_i,
  input  logic                            wb_we_i,
  output logic [NUM_SRC-1:0][OPSEL_W-1:0] opsel_o
);

  logic [NUM_SRC-1:0] hit_ex, hit_wb;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hzd_tag_cmp #(.REG_W(REG_W)) u_cmp_ex (
      .src_i     (rd_rs_i[g]),
      .src_use_i (rd_use_i[g]),
      .dst_i     (ex_rd_i),
      .dst_we_i  (ex_we_i),
      .hit_o     (hit_ex[g])
    );
    hzd_tag_cmp #(.REG_W(REG_W)) u_cmp_wb (
      .src_i     (rd_rs_i[g]),
      .src_use_i (rd_use_i[g]),
      .dst_i     (wb_rd_i),
      .dst_we_i  (wb_we_i),
      .hit_o     (hit_wb[g])
    );

    // younger producer wins
    always_comb begin
      if (hit_ex[g])      opsel_o[g] = OPSEL_EX;
      else if (hit_wb[g]) opsel_o[g] = OPSEL_WB;
      else                opsel_o[g] = OPSEL_RF;
    end
  end

endmodule

// File: rtl/hzd_bypass_unit.sv
module hzd_bypass_unit
  import hzd_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned REG_W   = 5
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [1:0]                      mode_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]   dec_rs_i,
  input  logic [NUM_SRC-1:0]              dec_rs_use_i,
  input  logic [REG_W-1:0]                dec_rd_i,
  input  logic                            dec_rd_we_i,
  output logic                            stall_o,
  output logic [NUM_SRC-1:0][OPSEL_W-1:0] opsel_o
);

  logic [NUM_SRC-1:0][REG_W-1:0] rd_rs;
  logic [NUM_SRC-1:0]            rd_use;
  logic [REG_W-1:0]              rd_rd, ex_rd, wb_rd;
  logic                          rd_we, ex_we, wb_we;
  logic                          stall;
  logic                          mode_none, mode_basic;

  hzd_tag_pipe #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_tag_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stall_i   (stall),
    .dec_rs_i  (dec_rs_i),
    .dec_use_i (dec_rs_use_i),
    .dec_rd_i  (dec_rd_i),
    .dec_we_i  (dec_rd_we_i),
    .rd_rs_o   (rd_rs),
    .rd_use_o  (rd_use),
    .rd_rd_o   (rd_rd),
    .rd_we_o   (rd_we),
    .ex_rd_o   (ex_rd),
    .ex_we_o   (ex_we),
    .wb_rd_o   (wb_rd),
    .wb_we_o   (wb_we)
  );

  hzd_stall_detect #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_stall (
    .mode_i    (mode_i),
    .dec_rs_i  (dec_rs_i),
    .dec_use_i (dec_rs_use_i),
    .rd_rd_i   (rd_rd),
    .rd_we_i   (rd_we),
    .ex_rd_i   (ex_rd),
    .ex_we_i   (ex_we),
    .stall_o   (stall)
  );

  hzd_fwd_sel #(.NUM_SRC(NUM_SRC), .REG_W(REG_W)) u_fwd (
    .rd_rs_i  (rd_rs),
    .rd_use_i (rd_use),
    .ex_rd_i  (ex_rd),
    .ex_we_i  (ex_we),
    .wb_rd_i  (wb_rd),
    .wb_we_i  (wb_we),
    .opsel_o  (opsel_o)
  );

  assign stall_o    = stall;
  assign mode_none  = (mode_i == BYP_NONE) || (mode_i == BYP_RSVD);
  assign mode_basic = (mode_i == BYP_BASIC);

  AST_NONE_STALL_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_none && stall && $past(stall)) |=> !stall); // R2
  AST_BASIC_STALL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_basic && stall) |=> !stall); // R9

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    AST_NONE_RF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_none |-> (opsel_o[g] == OPSEL_RF)); // R2
    AST_BASIC_NO_EX: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_basic |-> (opsel_o[g] != OPSEL_EX)); // R3
    AST_ZERO_NO_FWD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_use[g] && (rd_rs[g] == '0)) |-> (opsel_o[g] == OPSEL_RF)); // R5
  end

endmodule

// File: tb/hzd_bypass_unit_tb_top.sv
module hzd_bypass_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 2;
  localparam int RW = 5;
  localparam int MAXP = 8;

  typedef struct packed {
    logic       vld;
    logic       sub;
    logic [4:0] rd;
    logic       we;
    logic [4:0] rs1;
    logic       u1;
    logic [4:0] rs2;
    logic       u2;
  } instr_t;

  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] gap;
    logic        dep;
    logic [31:0] exp_stall;
    logic [1:0]  exp_sel;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 32'd0, 1'b1, 32'd2, 2'd0},
    '{2'd0, 32'd1, 1'b1, 32'd1, 2'd0},
    '{2'd0, 32'd2, 1'b1, 32'd0, 2'd0},
    '{2'd1, 32'd0, 1'b1, 32'd1, 2'd1},
    '{2'd1, 32'd1, 1'b1, 32'd0, 2'd1},
    '{2'd1, 32'd2, 1'b1, 32'd0, 2'd0},
    '{2'd2, 32'd0, 1'b1, 32'd0, 2'd2},
    '{2'd2, 32'd1, 1'b1, 32'd0, 2'd1},
    '{2'd2, 32'd2, 1'b1, 32'd0, 2'd0},
    '{2'd3, 32'd0, 1'b1, 32'd2, 2'd0},
    '{2'd0, 32'd0, 1'b0, 32'd0, 2'd0},
    '{2'd2, 32'd0, 1'b0, 32'd0, 2'd0}
  };

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [1:0]               mode = 2'd0;
  logic [NSRC-1:0][RW-1:0]  dec_rs = '0;
  logic [NSRC-1:0]          dec_use = '0;
  logic [RW-1:0]            dec_rd = '0;
  logic                     dec_we = 1'b0;
  logic                     stall;
  logic [NSRC-1:0][1:0]     opsel;

  instr_t      prog [MAXP];
  int          prog_len;
  logic [31:0] rf [32];
  logic [31:0] ref_rf [32];
  logic [1:0]  rec_a [MAXP];
  logic [1:0]  rec_b [MAXP];
  int          stall_cnt;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hzd_bypass_unit #(.NUM_SRC(NSRC), .REG_W(RW)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_i       (mode),
    .dec_rs_i     (dec_rs),
    .dec_rs_use_i (dec_use),
    .dec_rd_i     (dec_rd),
    .dec_rd_we_i  (dec_we),
    .stall_o      (stall),
    .opsel_o      (opsel)
  );

  function automatic instr_t mk(logic sub, logic [4:0] rd, logic we,
                                logic [4:0] rs1, logic u1, logic [4:0] rs2, logic u2);
    instr_t t;
    t.vld = 1'b1; t.sub = sub; t.rd = rd; t.we = we;
    t.rs1 = rs1; t.u1 = u1; t.rs2 = rs2; t.u2 = u2;
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_dec(input instr_t t);
    dec_rs[0] = t.rs1;
    dec_rs[1] = t.rs2;
    dec_use   = {t.u2 & t.vld, t.u1 & t.vld};
    dec_rd    = t.rd;
    dec_we    = t.we & t.vld;
  endtask

  function automatic logic [31:0] opval(logic [1:0] sel, logic [4:0] rs, logic u,
                                        logic [31:0] wres, logic [31:0] alu);
    if (!u) return 32'd0;
    case (sel)
      2'd0:    return rf[rs];
      2'd1:    return wres;
      2'd2:    return alu;
      default: return 32'hdead_beef;
    endcase
  endfunction

  // datapath model around the unit, plus sequential reference
  task automatic run_prog(input logic [1:0] m);
    instr_t      bub, pr, pe, pw;
    int          ir, pc;
    logic [31:0] ea, eb, wres, alu, va, vb, a, b, res;
    logic        st;
    logic [1:0]  sa, sb;
    bub = '0; pr = '0; pe = '0; pw = '0;
    ir = 0; pc = 0; ea = 0; eb = 0; wres = 0;
    mode = m;
    stall_cnt = 0;
    for (int i = 0; i < 32; i++) begin
      rf[i] = (i == 0) ? 32'd0 : 32'(i * 3 + 2);
      ref_rf[i] = rf[i];
    end
    for (int i = 0; i < MAXP; i++) begin
      rec_a[i] = 2'd3;
      rec_b[i] = 2'd3;
    end
    for (int i = 0; i < prog_len; i++) begin
      a = prog[i].u1 ? ref_rf[prog[i].rs1] : 32'd0;
      b = prog[i].u2 ? ref_rf[prog[i].rs2] : 32'd0;
      res = prog[i].sub ? a - b : a + b;
      if (prog[i].we && prog[i].rd != 0) ref_rf[prog[i].rd] = res;
    end
    drive_dec(prog[0]);
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      st = stall; sa = opsel[0]; sb = opsel[1];
      alu = pe.sub ? ea - eb : ea + eb;
      va = opval(sa, pr.rs1, pr.u1, wres, alu);
      vb = opval(sb, pr.rs2, pr.u2, wres, alu);
      if (pr.vld) begin rec_a[ir] = sa; rec_b[ir] = sb; end
      if (st) stall_cnt++;
      @(posedge clk);
      #1;
      if (pw.vld && pw.we && pw.rd != 0) rf[pw.rd] = wres;
      pw = pe; wres = alu;
      pe = pr; ea = va; eb = vb;
      if (st) pr = bub;
      else if (pc < prog_len) begin pr = prog[pc]; ir = pc; pc++; end
      else pr = bub;
      drive_dec(pc < prog_len ? prog[pc] : bub);
      if (pc >= prog_len && !pr.vld && !pe.vld && !pw.vld) break;
    end
  endtask

  task automatic check_regs(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < 32; i++) if (rf[i] !== ref_rf[i]) bad++;
    check(bad == 0, req, "registers differing from sequential result", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    instr_t t;
    // R1: reset with a dependent-looking decode instruction
    mode = 2'd0;
    t = mk(0, 5'd3, 1, 5'd3, 1, 5'd3, 1);
    drive_dec(t);
    #(CLK_PERIOD * 2 + 3);
    check(stall == 1'b0, "R1", "stall in reset", stall, 0);
    check(opsel == '0, "R1", "opsel in reset", opsel, 0);
    drive_dec('0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(stall == 1'b0 && opsel == '0, "R1", "outputs after reset", {opsel, stall}, 0);

    // table of mode / distance scenarios
    foreach (VECS[v]) begin
      int cons;
      prog[0] = mk(0, 5'd3, 1, 5'd1, 1, 5'd2, 1);
      for (int k = 0; k < int'(VECS[v].gap); k++)
        prog[1 + k] = mk(0, 5'(10 + k), 1, 5'd1, 1, 5'd2, 1);
      cons = int'(VECS[v].gap) + 1;
      prog[cons] = mk(1, 5'd4, 1, VECS[v].dep ? 5'd3 : 5'd2, 1, 5'd1, 1);
      prog_len = cons + 1;
      run_prog(VECS[v].mode);
      // R2 R3 R4 R10 R11 by mode/dep
      check(stall_cnt == int'(VECS[v].exp_stall),
            VECS[v].dep ? (VECS[v].mode == 0 ? "R2" : VECS[v].mode == 1 ? "R3" :
                           VECS[v].mode == 2 ? "R4" : "R10") : "R11",
            $sformatf("stall cycles vec %0d", v), stall_cnt, VECS[v].exp_stall);
      check(rec_a[cons] == VECS[v].exp_sel,
            VECS[v].dep ? (VECS[v].mode == 0 ? "R2" : VECS[v].mode == 1 ? "R3" :
                           VECS[v].mode == 2 ? "R4" : "R10") : "R11",
            $sformatf("opsel vec %0d", v), rec_a[cons], VECS[v].exp_sel);
      check_regs("R9");
    end

    // R5: producer writes register 0, consumer reads register 0
    prog[0] = mk(0, 5'd0, 1, 5'd1, 1, 5'd2, 1);
    prog[1] = mk(0, 5'd4, 1, 5'd0, 1, 5'd1, 1);
    prog_len = 2;
    run_prog(2'd2);
    check(stall_cnt == 0, "R5", "stall on r0", stall_cnt, 0);
    check(rec_a[1] == 2'd0, "R5", "opsel on r0", rec_a[1], 0);
    run_prog(2'd0);
    check(stall_cnt == 0, "R5", "stall on r0 mode0", stall_cnt, 0);
    check_regs("R5");

    // R6: matching register, write-enable low
    prog[0] = mk(0, 5'd3, 0, 5'd1, 1, 5'd2, 1);
    prog[1] = mk(1, 5'd4, 1, 5'd3, 1, 5'd1, 1);
    prog_len = 2;
    run_prog(2'd0);
    check(stall_cnt == 0, "R6", "stall on disabled write", stall_cnt, 0);
    run_prog(2'd2);
    check(rec_a[1] == 2'd0, "R6", "opsel on disabled write", rec_a[1], 0);
    check_regs("R6");

    // R7: both execute and write hold r3
    prog[0] = mk(0, 5'd3, 1, 5'd1, 1, 5'd2, 1);
    prog[1] = mk(1, 5'd3, 1, 5'd2, 1, 5'd1, 1);
    prog[2] = mk(0, 5'd4, 1, 5'd3, 1, 5'd1, 1);
    prog_len = 3;
    run_prog(2'd2);
    check(rec_a[2] == 2'd2, "R7", "younger producer select", rec_a[2], 2);
    check_regs("R7");

    // R8: dependency on the second source only
    prog[0] = mk(0, 5'd3, 1, 5'd1, 1, 5'd2, 1);
    prog[1] = mk(1, 5'd4, 1, 5'd1, 1, 5'd3, 1);
    prog_len = 2;
    run_prog(2'd1);
    check(stall_cnt == 1, "R8", "stall from second source", stall_cnt, 1);
    check(rec_a[1] == 2'd0, "R8", "first source select", rec_a[1], 0);
    check(rec_b[1] == 2'd1, "R8", "second source select", rec_b[1], 1);
    check_regs("R8");

    // R8: each source from a different producer
    prog[0] = mk(0, 5'd5, 1, 5'd1, 1, 5'd2, 1);
    prog[1] = mk(1, 5'd6, 1, 5'd2, 1, 5'd1, 1);
    prog[2] = mk(0, 5'd7, 1, 5'd5, 1, 5'd6, 1);
    prog_len = 3;
    run_prog(2'd2);
    check(rec_a[2] == 2'd1 && rec_b[2] == 2'd2, "R8", "split selects",
          {rec_a[2], rec_b[2]}, {2'd1, 2'd2});
    check_regs("R8");
    run_prog(2'd0);
    check(stall_cnt == 2, "R8", "stall with both sources pending", stall_cnt, 2);
    check_regs("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule